// File: doc/BRIEF.md
# EPROM Byte-Programming Control Register

This block is a single memory-mapped byte register that controls the programming of an on-chip EPROM. Software writes two control bits: a latch bit that chooses between reading the array and latching an address and data byte into it, and a program-inhibit bit that opens or closes the programming path. A third bit is read-only. It reports whether high voltage is present on the programming supply pin, as seen through a synchronizer.

The register applies an ordering interlock. Programming can only be enabled after the latch bit has already been cleared by an earlier write, so the state "programming enabled while reading" can never be stored. A safety gate sits between the register and the array. While no high voltage is sensed, the array sees plain read mode whatever the register holds. Stray writes during normal operation therefore cannot disturb the EPROM.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: After reset the latch bit (bit 0) and the program-inhibit bit (bit 1) are both 1. With the supply pin high, a read returns 0x07, and the array outputs show read mode: arrReadSel=1, arrLatch=0, arrProgram=0.
- R2: Only the address REG_ADDR (default 0x08) is decoded. A write to any other address changes nothing. A read of any other address returns 0x00.
- R3: A write to REG_ADDR always stores write-data bit 0 into the latch bit.
- R4: A write clears the program-inhibit bit only when the stored latch bit is already 0 and write-data bit 0 is 0. Otherwise the inhibit bit becomes 1, even when write-data bit 1 is 0. This also covers a single write that sets the latch bit and clears bit 1.
- R5: A read never returns bit 1 = 0 together with bit 0 = 1.
- R6: Writes to bit 2 and to bits 7..3 are ignored. Bits 7..3 always read 0.
- R7: Read bit 2 follows the supply-sense pin hvSenseN (0 = high voltage present) through a two-stage synchronizer. A change on the pin appears on a read after the second rising clock edge, not after the first.
- R8: While the synchronized sense bit is 1, the array outputs are arrReadSel=1, arrLatch=0 and arrProgram=0 whatever the stored bits.
- R9: While the synchronized sense bit is 0, arrReadSel equals the latch bit and arrLatch is its inverse.
- R10: arrProgram is 1 exactly when the synchronized sense bit, the latch bit and the program-inhibit bit are all 0.
- R11: A write with data bit 1 = 1 always sets the program-inhibit bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | ADDR_W | Bus address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational, 0 when not addressed) |
| hvSenseN | input | 1 | Asynchronous supply-sense pin, 0 = high voltage present |
| arrLatch | output | 1 | To array: latch address and data |
| arrReadSel | output | 1 | To array: read select |
| arrProgram | output | 1 | To array: program strobe |

## Verification
The bench goes after the two-step interlock. A design that checks the incoming latch bit but not the stored one would enable programming on the first write of 0x00 from reset. A design that ignores the incoming latch bit would store the forbidden combination after a write of 0x01. Stray writes are made while no high voltage is sensed, and the array outputs are checked to stay in read mode; a missing gate would show a program strobe there. The sense bit is sampled after one and after two clock edges to catch a missing or extra synchronizer stage. Writes with bit 2 and the upper bits set, and accesses to a neighbouring address, expose a loose decode or a writable status bit.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int DATA_W    = 8;
  localparam int LATCH_BIT = 0;
  localparam int PROG_BIT  = 1;
  localparam int SENSE_BIT = 2;

  typedef struct packed {
    logic wrHit;
    logic rdHit;
  } epcStrobe_t;
endpackage

// File: rtl/epc_sync.sv
module epc_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[gi] <= RESET_VAL;
          else       chain[gi] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[gi] <= RESET_VAL;
          else       chain[gi] <= chain[gi-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/epc_control.sv
module epc_control
  import epc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h08
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output epcStrobe_t        strobe
);
  logic addrMatch;

  always_comb begin
    addrMatch    = (busAddr == REG_ADDR);
    strobe.wrHit = busWrEn & addrMatch;
    strobe.rdHit = busRdEn & addrMatch;
  end
endmodule

// File: rtl/epc_datapath.sv
module epc_datapath
  import epc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  epcStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hvSenseN,
  output logic [DATA_W-1:0] rdData,
  output logic              arrLatch,
  output logic              arrReadSel,
  output logic              arrProgram
);
  logic latchCtl;
  logic progCtl;
  logic hvSync;
  logic gateOpen;

  epc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(hvSenseN),
    .syncOut(hvSync)
  );

  // The inhibit bit may drop only when latch is already clear and stays clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchCtl <= 1'b1;
      progCtl  <= 1'b1;
    end else if (strobe.wrHit) begin
      latchCtl <= wrData[LATCH_BIT];
      progCtl  <= wrData[PROG_BIT] | wrData[LATCH_BIT] | latchCtl;
    end
  end

  always_comb begin
    gateOpen   = ~hvSync;
    arrReadSel = gateOpen ? latchCtl : 1'b1;
    arrLatch   = gateOpen & ~latchCtl;
    arrProgram = gateOpen & ~latchCtl & ~progCtl;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdHit) begin
      rdData[LATCH_BIT] = latchCtl;
      rdData[PROG_BIT]  = progCtl;
      rdData[SENSE_BIT] = hvSync;
    end
  end
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import epc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h08,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              hvSenseN,
  output logic              arrLatch,
  output logic              arrReadSel,
  output logic              arrProgram
);
  epcStrobe_t strobe;

  epc_control #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strobe (strobe)
  );

  epc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData),
    .hvSenseN  (hvSenseN),
    .rdData    (busRdData),
    .arrLatch  (arrLatch),
    .arrReadSel(arrReadSel),
    .arrProgram(arrProgram)
  );
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h08
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [7:0]        busWrData,
  input logic [7:0]        busRdData,
  input logic              arrLatch,
  input logic              arrReadSel,
  input logic              arrProgram
);
  logic rdHit;
  assign rdHit = busRdEn && (busAddr == REG_ADDR);

  assert_other_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr != REG_ADDR) |-> busRdData == 8'h00);

  assert_latch_blocks_prog_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_ADDR && busWrData[0]) |=> !arrProgram);

  assert_no_bad_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && !busRdData[1]) |-> !busRdData[0]);

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[7:3] == 5'b0);

  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && busRdData[2]) |-> (arrReadSel && !arrLatch && !arrProgram));

  assert_mode_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && !busRdData[2]) |-> (arrReadSel == busRdData[0] && arrLatch == !busRdData[0]));

  assert_strobe_cond_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && !busRdData[2]) |-> (arrProgram == (!busRdData[0] && !busRdData[1])));

  assert_prog_in_latch_R10: assert property (@(posedge clk) disable iff (!rstN)
    arrProgram |-> (arrLatch && !arrReadSel));
endmodule

bind eprom_prog_ctrl epc_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .arrLatch  (arrLatch),
  .arrReadSel(arrReadSel),
  .arrProgram(arrProgram)
);

// File: tb/eprom_prog_ctrl_bench.sv
module eprom_prog_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       hvSenseN = 1'b1;
  logic       arrLatch, arrReadSel, arrProgram;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  eprom_prog_ctrl u_eprom_prog_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .hvSenseN(hvSenseN), .arrLatch(arrLatch), .arrReadSel(arrReadSel),
    .arrProgram(arrProgram)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] addr, output logic [7:0] val);
    busAddr = addr; busRdEn = 1'b1;
    #1 val = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic checkArr(input string req, input logic rs, input logic la, input logic pg);
    check(req, {arrReadSel, arrLatch, arrProgram}, {rs, la, pg});
  endtask

  task automatic testReset();
    logic [7:0] v;
    readReg(8'h08, v);
    check("R1 reset value", v, 8'h07);
    checkArr("R1 reset array outputs", 1, 0, 0);
  endtask

  task automatic testInterlockNoHv();
    logic [7:0] v;
    writeReg(8'h08, 8'h00);
    readReg(8'h08, v);
    check("R4 first clear keeps inhibit", v, 8'h06);
    checkArr("R8 gate closed latch0", 1, 0, 0);
    writeReg(8'h08, 8'h00);
    readReg(8'h08, v);
    check("R4 second clear drops inhibit", v, 8'h04);
    checkArr("R8 gate closed prog armed", 1, 0, 0);
  endtask

  task automatic testSyncAndProgram();
    logic [7:0] v;
    @(negedge clk); hvSenseN = 1'b0;
    @(negedge clk);
    readReg(8'h08, v);
    check("R7 one edge still absent", v[2], 1);
    checkArr("R8 still closed after one edge", 1, 0, 0);
    @(negedge clk);
    readReg(8'h08, v);
    check("R7 two edges present", v, 8'h00);
    checkArr("R10 program strobe", 0, 1, 1);
  endtask

  task automatic testForcedInhibit();
    logic [7:0] v;
    writeReg(8'h08, 8'h01);
    readReg(8'h08, v);
    check("R4 set latch with clear inhibit", v, 8'h03);
    check("R5 no forbidden pair", v[1:0] == 2'b01, 0);
    checkArr("R9 read mode", 1, 0, 0);
    writeReg(8'h08, 8'h00);
    readReg(8'h08, v);
    check("R4 clear from latch1 keeps inhibit", v, 8'h02);
    checkArr("R9 latch mode no program", 0, 1, 0);
    writeReg(8'h08, 8'h00);
    readReg(8'h08, v);
    check("R3 latch stays clear", v, 8'h00);
    checkArr("R10 program again", 0, 1, 1);
  endtask

  task automatic testIgnoredBits();
    logic [7:0] v;
    writeReg(8'h08, 8'hFE);
    readReg(8'h08, v);
    check("R6 bit2 and upper ignored", v, 8'h02);
    check("R11 inhibit set", v[1], 1);
    checkArr("R10 inhibited", 0, 1, 0);
    writeReg(8'h08, 8'hF8);
    readReg(8'h08, v);
    check("R6 upper ignored on clear", v, 8'h00);
  endtask

  task automatic testDecode();
    logic [7:0] v;
    writeReg(8'h09, 8'h03);
    writeReg(8'h00, 8'h03);
    readReg(8'h08, v);
    check("R2 foreign writes no effect", v, 8'h00);
    checkArr("R2 outputs unchanged", 0, 1, 1);
    readReg(8'h09, v);
    check("R2 foreign read zero", v, 8'h00);
  endtask

  task automatic testGateDrop();
    logic [7:0] v;
    @(negedge clk); hvSenseN = 1'b1;
    @(negedge clk);
    checkArr("R7 one edge still open", 0, 1, 1);
    @(negedge clk);
    readReg(8'h08, v);
    check("R7 sense returns", v, 8'h04);
    checkArr("R8 closed with armed bits", 1, 0, 0);
    writeReg(8'h08, 8'h03);
    readReg(8'h08, v);
    check("R3 R11 set both", v, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInterlockNoHv();
    testSyncAndProgram();
    testForcedInhibit();
    testIgnoredBits();
    testDecode();
    testGateDrop();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule